// File: doc/BRIEF.md
# Inbound Transfer CRC-32 Checker

This block keeps a running CRC-32 over the 32-bit words of an inbound double-transition data transfer. It compares the running value with the CRC word the sequencer presents on a check pulse. A failed comparison raises a sticky error flag. An 8-bit control register sets the reseed policy, selects what a 32-bit data view shows on a read, and gives software three self-clearing test strobes: reseed now, check now, and fold the input register into the CRC.

The accumulator takes one word per cycle. It uses polynomial 0x04C11DB7, shifts most significant bit first with no reflection, and starts from the seed 0xFFFFFFFF. Reseeding happens when the sequencer asks for it, when software uses the test strobe, or automatically on the cycle after each check if auto-seed is on. The error flag clears when software writes a one to it or reads the interrupt status. A masked copy of the flag drives an interrupt-status bit.

Top module: `dtin_crc_checker`

## Requirements
- R1: After reset the accumulator holds 0xFFFFFFFF, the control register reads 0x00, and both crc_err and irq_stat are low.
- R2: Each cycle with in_valid high replaces the accumulator with the CRC-32 update of (accumulator, in_word), visible after that edge, and loads in_word into the input register.
- R3: A check is taken when seq_check and dt_in_active are both high. It captures seq_crc_word as the received word and sets crc_err on that edge if the accumulator differs from seq_crc_word. A match, or seq_check with dt_in_active low, leaves crc_err unchanged.
- R4: crc_err is sticky. A control write (reg_sel 00) with bit 7 = 1 clears it, and a control write with bit 7 = 0 leaves it set.
- R5: A cycle with reg_rd high and reg_sel 10 (interrupt status) clears crc_err. In that region reg_rdata bit 0 is irq_stat and the other bits are zero.
- R6: When a new mismatch and a clear request fall in the same cycle, crc_err ends up set.
- R7: crc_err sets whatever chk_en and perr_irq_en are. irq_stat is high only when crc_err, chk_en and perr_irq_en are all high.
- R8: Control read layout: bit 7 is the flag, bit 5 is auto-seed, bits 1:0 are the view selector. Bit 6 and the strobe bits 4:2 always read 0.
- R9: With auto-seed (bit 5) at 1, the accumulator is unchanged right after a check edge and holds the seed after the following edge. With bit 5 at 0 a check leaves the accumulator alone. A seq_reseed pulse always reloads the seed at its edge.
- R10: A control write with bit 4 = 1 reloads the seed at that edge.
- R11: A control write with bit 3 = 1 compares the accumulator with the stored received word and sets crc_err on mismatch, even with dt_in_active low.
- R12: A control write with bit 2 = 1 (and in_valid low) folds the input register into the accumulator, exactly as a received word would be.
- R13: A data-region read (reg_sel 01) shows: selector 00 the accumulator, 01 the received word, 10 the input register, 11 the seed.
- R14: A data-region write (reg_wr, reg_sel 01) loads reg_wdata into the input register when in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | in_word carries a data word this cycle |
| in_word | input | 32 | Inbound data word |
| dt_in_active | input | 1 | An inbound double-transition data transfer is in progress |
| seq_check | input | 1 | Sequencer check pulse |
| seq_crc_word | input | 32 | Received CRC word that comes with seq_check |
| seq_reseed | input | 1 | Sequencer reseed pulse |
| chk_en | input | 1 | CRC checking is enabled |
| perr_irq_en | input | 1 | Parity/CRC interrupt is enabled |
| reg_sel | input | 2 | Register region: 00 control, 01 data, 10 interrupt status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect on interrupt status) |
| reg_wdata | input | 32 | Write data (control uses bits 7:0) |
| reg_rdata | output | 32 | Read data for the region reg_sel selects |
| crc_err | output | 1 | Sticky CRC error flag |
| irq_stat | output | 1 | Masked copy of the error flag for the interrupt status |

## Verification
The hardest case to reach from the ports is a set and a clear of the error flag in the same cycle. The bench drives a mismatching sequencer check together with a write-one-to-clear control write in one clock. Auto-seed timing is also delicate. The bench sets the view selector to the accumulator in advance, so it can sample the data region with no control write both right after the check edge and one edge later. The test-check strobe needs a running CRC that differs from the stored received word, so the bench accumulates an extra word before firing it with the transfer qualifier low.

// File: rtl/dtcrc_pkg.sv
package dtcrc_pkg;
   typedef enum logic [1:0] {
      RG_CTRL  = 2'd0,
      RG_DATA  = 2'd1,
      RG_ISTAT = 2'd2,
      RG_NONE  = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      VW_ACC  = 2'd0,
      VW_RX   = 2'd1,
      VW_IN   = 2'd2,
      VW_SEED = 2'd3
   } view_e;

   localparam int CB_FLAG  = 7;
   localparam int CB_AUTO  = 5;
   localparam int CB_TSEED = 4;
   localparam int CB_TCHK  = 3;
   localparam int CB_TADD  = 2;
   localparam int CTRL_W   = 8;
endpackage

// File: rtl/dtcrc_step.sv
module dtcrc_step #(
   parameter int          CW   = 32,
   parameter int          DW   = 32,
   parameter logic [CW-1:0] POLY = 32'h04C1_1DB7
) (
   input  logic [CW-1:0] c_in,
   input  logic [DW-1:0] d_in,
   output logic [CW-1:0] c_out
);
   always_comb begin
      logic [CW-1:0] c;
      c = c_in;
      for (int i = DW - 1; i >= 0; i--) begin
         if (c[CW-1] ^ d_in[i]) c = {c[CW-2:0], 1'b0} ^ POLY;
         else                   c = {c[CW-2:0], 1'b0};
      end
      c_out = c;
   end
endmodule

// File: rtl/dtcrc_ctl.sv
module dtcrc_ctl
   import dtcrc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              w_flag,
   input  logic              w_auto,
   input  logic              w_seed,
   input  logic              w_chk,
   input  logic              w_add,
   input  logic [1:0]        w_dsel,
   input  logic              istat_rd,
   input  logic              err_set,
   output logic              flag_q,
   output logic              auto_q,
   output view_e             dsel_q,
   output logic              t_seed,
   output logic              t_chk,
   output logic              t_add,
   output logic [CTRL_W-1:0] ctl_rd
);
   logic clr_req;

   assign clr_req = (wr_ctl & w_flag) | istat_rd;
   assign t_seed  = wr_ctl & w_seed;
   assign t_chk   = wr_ctl & w_chk;
   assign t_add   = wr_ctl & w_add;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         auto_q <= 1'b0;
         dsel_q <= VW_ACC;
      end else begin
         if (err_set)      flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
         if (wr_ctl) begin
            auto_q <= w_auto;
            dsel_q <= view_e'(w_dsel);
         end
      end
   end

   always_comb begin
      ctl_rd           = '0;
      ctl_rd[CB_FLAG]  = flag_q;
      ctl_rd[CB_AUTO]  = auto_q;
      ctl_rd[1:0]      = dsel_q;
   end
endmodule

// File: rtl/dtcrc_datapath.sv
module dtcrc_datapath
   import dtcrc_pkg::*;
#(
   parameter int            CW   = 32,
   parameter logic [CW-1:0] POLY = 32'h04C1_1DB7,
   parameter logic [CW-1:0] SEED = 32'hFFFF_FFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [CW-1:0] in_word,
   input  logic          chk_evt,
   input  logic [CW-1:0] seq_crc_word,
   input  logic          t_chk,
   input  logic          reseed_req,
   input  logic          t_add,
   input  logic          data_wr,
   input  logic [CW-1:0] data_wdata,
   input  logic          auto_en,
   input  view_e         dsel,
   output logic [CW-1:0] acc_q,
   output logic [CW-1:0] view_rd,
   output logic          err_set
);
   logic [CW-1:0] in_q, rx_q, fold_d, acc_nx, cmp_word;
   logic          auto_pend, any_chk;

   assign fold_d   = in_valid ? in_word : in_q;
   assign cmp_word = chk_evt ? seq_crc_word : rx_q;
   assign any_chk  = chk_evt | t_chk;
   assign err_set  = any_chk & (acc_q != cmp_word);

   dtcrc_step #(.CW(CW), .DW(CW), .POLY(POLY)) u_step (
      .c_in  (acc_q),
      .d_in  (fold_d),
      .c_out (acc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= SEED;
         in_q      <= '0;
         rx_q      <= '0;
         auto_pend <= 1'b0;
      end else begin
         auto_pend <= any_chk & auto_en;
         if (reseed_req || auto_pend)  acc_q <= SEED;
         else if (in_valid || t_add)   acc_q <= acc_nx;
         if (in_valid)     in_q <= in_word;
         else if (data_wr) in_q <= data_wdata;
         if (chk_evt) rx_q <= seq_crc_word;
      end
   end

   always_comb begin
      unique case (dsel)
         VW_ACC:  view_rd = acc_q;
         VW_RX:   view_rd = rx_q;
         VW_IN:   view_rd = in_q;
         default: view_rd = SEED;
      endcase
   end
endmodule

// File: rtl/dtin_crc_checker.sv
module dtin_crc_checker
   import dtcrc_pkg::*;
#(
   parameter int            CW   = 32,
   parameter logic [CW-1:0] POLY = 32'h04C1_1DB7,
   parameter logic [CW-1:0] SEED = 32'hFFFF_FFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [CW-1:0] in_word,
   input  logic          dt_in_active,
   input  logic          seq_check,
   input  logic [CW-1:0] seq_crc_word,
   input  logic          seq_reseed,
   input  logic          chk_en,
   input  logic          perr_irq_en,
   input  logic [1:0]    reg_sel,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [CW-1:0] reg_wdata,
   output logic [CW-1:0] reg_rdata,
   output logic          crc_err,
   output logic          irq_stat
);
   localparam int PAD_W = CW - CTRL_W;

   if (CW < CTRL_W) begin : g_bad_width
      $error("dtin_crc_checker: CW must be at least the control width");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("dtin_crc_checker: POLY needs its constant term set");
   end

   logic              wr_ctl, data_wr, istat_rd, chk_evt, err_set;
   logic              t_seed, t_chk, t_add, auto_w;
   view_e             dsel_w;
   logic [CTRL_W-1:0] ctl_rd;
   logic [CW-1:0]     view_rd, acc_w;

   assign wr_ctl   = reg_wr & (region_e'(reg_sel) == RG_CTRL);
   assign data_wr  = reg_wr & (region_e'(reg_sel) == RG_DATA);
   assign istat_rd = reg_rd & (region_e'(reg_sel) == RG_ISTAT);
   assign chk_evt  = seq_check & dt_in_active;

   dtcrc_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_ctl),
      .w_flag   (reg_wdata[CB_FLAG]),
      .w_auto   (reg_wdata[CB_AUTO]),
      .w_seed   (reg_wdata[CB_TSEED]),
      .w_chk    (reg_wdata[CB_TCHK]),
      .w_add    (reg_wdata[CB_TADD]),
      .w_dsel   (reg_wdata[1:0]),
      .istat_rd (istat_rd),
      .err_set  (err_set),
      .flag_q   (crc_err),
      .auto_q   (auto_w),
      .dsel_q   (dsel_w),
      .t_seed   (t_seed),
      .t_chk    (t_chk),
      .t_add    (t_add),
      .ctl_rd   (ctl_rd)
   );

   dtcrc_datapath #(.CW(CW), .POLY(POLY), .SEED(SEED)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_word      (in_word),
      .chk_evt      (chk_evt),
      .seq_crc_word (seq_crc_word),
      .t_chk        (t_chk),
      .reseed_req   (seq_reseed | t_seed),
      .t_add        (t_add),
      .data_wr      (data_wr),
      .data_wdata   (reg_wdata),
      .auto_en      (auto_w),
      .dsel         (dsel_w),
      .acc_q        (acc_w),
      .view_rd      (view_rd),
      .err_set      (err_set)
   );

   assign irq_stat = crc_err & chk_en & perr_irq_en;

   always_comb begin
      unique case (region_e'(reg_sel))
         RG_CTRL:  reg_rdata = {{PAD_W{1'b0}}, ctl_rd};
         RG_DATA:  reg_rdata = view_rd;
         RG_ISTAT: reg_rdata = {{(CW-1){1'b0}}, irq_stat};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dtcrc_props.sv
module dtcrc_props #(
   parameter int            CW   = 32,
   parameter logic [CW-1:0] SEED = 32'hFFFF_FFFF
) (
   input logic          clk,
   input logic          rst_n,
   input logic          seq_check,
   input logic          dt_in_active,
   input logic [CW-1:0] seq_crc_word,
   input logic          seq_reseed,
   input logic [CW-1:0] acc,
   input logic          auto_en,
   input logic [1:0]    reg_sel,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic          wclr_bit,
   input logic [4:0]    ctl_mid,
   input logic          crc_err,
   input logic          irq_stat
);
   logic new_err, wr_clr, st_rd;
   assign new_err = seq_check && dt_in_active && (seq_crc_word != acc);
   assign wr_clr  = reg_wr && (reg_sel == 2'd0) && wclr_bit;
   assign st_rd   = reg_rd && (reg_sel == 2'd2);

   p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      new_err |=> crc_err);

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err && !wr_clr && !st_rd) |=> crc_err);

   p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !(seq_check && dt_in_active)) |=> !crc_err);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (new_err && wr_clr) |=> crc_err);

   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_stat |-> crc_err);

   p_ctl_zero_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd0) |-> ((ctl_mid & 5'b10111) == 5'b0));

   p_auto_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && seq_check && dt_in_active) |=> ##1 (acc == SEED));

   p_seq_reseed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_reseed |=> (acc == SEED));
endmodule

bind dtin_crc_checker dtcrc_props #(.CW(CW), .SEED(SEED)) u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .seq_check    (seq_check),
   .dt_in_active (dt_in_active),
   .seq_crc_word (seq_crc_word),
   .seq_reseed   (seq_reseed),
   .acc          (acc_w),
   .auto_en      (auto_w),
   .reg_sel      (reg_sel),
   .reg_wr       (reg_wr),
   .reg_rd       (reg_rd),
   .wclr_bit     (reg_wdata[7]),
   .ctl_mid      (reg_rdata[6:2]),
   .crc_err      (crc_err),
   .irq_stat     (irq_stat)
);

// File: tb/dtin_crc_checker_tb.sv
`timescale 1ns/1ps
module dtin_crc_checker_tb;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;
   localparam logic [31:0] SEED = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 0, dt_in_active = 0, seq_check = 0, seq_reseed = 0;
   logic        chk_en = 0, perr_irq_en = 0, reg_wr = 0, reg_rd = 0;
   logic [31:0] in_word = '0, seq_crc_word = '0, reg_wdata = '0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_rdata;
   logic        crc_err, irq_stat;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] ref_acc = SEED;
   logic [31:0] ref_rx = '0;
   bit auto_b = 0;

   always #5 clk = ~clk;

   dtin_crc_checker u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .dt_in_active(dt_in_active), .seq_check(seq_check),
      .seq_crc_word(seq_crc_word), .seq_reseed(seq_reseed), .chk_en(chk_en),
      .perr_irq_en(perr_irq_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .crc_err(crc_err), .irq_stat(irq_stat)
   );

   function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] d);
      logic [31:0] x = c ^ d;
      for (int k = 0; k < 32; k++) x = x[31] ? ((x << 1) ^ POLY) : (x << 1);
      return x;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ctrl(logic [7:0] v);
      reg_sel = 2'd0; reg_wr = 1'b1; reg_wdata = {24'd0, v};
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic view(logic [1:0] dsel, output logic [31:0] v);
      wr_ctrl({2'b00, auto_b, 3'b000, dsel});
      reg_sel = 2'd1; #1;
      v = reg_rdata;
   endtask

   task automatic send_word(logic [31:0] w);
      in_valid = 1'b1; in_word = w;
      step();
      in_valid = 1'b0;
      ref_acc = ref_step(ref_acc, w);
   endtask

   task automatic seq_chk(logic [31:0] w, logic dt);
      seq_check = 1'b1; dt_in_active = dt; seq_crc_word = w;
      step();
      seq_check = 1'b0; dt_in_active = 1'b0;
      if (dt) ref_rx = w;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      reg_sel = 2'd0; #1;
      check("R1 ctrl after reset", reg_rdata, 32'h0);
      check("R1 crc_err after reset", {31'd0, crc_err}, 32'd0);
      check("R1 irq_stat after reset", {31'd0, irq_stat}, 32'd0);
      view(2'd0, v);
      check("R1 accumulator after reset", v, SEED);
   endtask

   task automatic t_accum();
      logic [31:0] v;
      send_word(32'h1234_5678);
      send_word(32'hDEAD_BEEF);
      send_word(32'h0000_0001);
      view(2'd0, v);
      check("R2 accumulator after three words", v, ref_acc);
      view(2'd2, v);
      check("R2 input register holds last word", v, 32'h0000_0001);
      view(2'd3, v);
      check("R13 seed view", v, SEED);
   endtask

   task automatic t_check_paths();
      logic [31:0] v;
      seq_chk(ref_acc, 1'b1);
      check("R3 matching check leaves flag low", {31'd0, crc_err}, 32'd0);
      view(2'd1, v);
      check("R3 received word captured", v, ref_acc);
      view(2'd0, v);
      check("R9 no reseed with auto-seed off", v, ref_acc);
      seq_chk(~ref_acc, 1'b0);
      check("R3 check outside transfer ignored", {31'd0, crc_err}, 32'd0);
      view(2'd1, v);
      check("R3 received word kept outside transfer", v, ref_rx);
   endtask

   task automatic t_mismatch_irq();
      seq_chk(ref_acc ^ 32'h0000_0100, 1'b1);
      check("R3 mismatch sets flag", {31'd0, crc_err}, 32'd1);
      check("R7 irq masked with enables off", {31'd0, irq_stat}, 32'd0);
      chk_en = 1'b1; #1;
      check("R7 irq masked by interrupt enable", {31'd0, irq_stat}, 32'd0);
      perr_irq_en = 1'b1; reg_sel = 2'd2; #1;
      check("R7 irq with both enables", {31'd0, irq_stat}, 32'd1);
      check("R5 status read value", reg_rdata, 32'd1);
   endtask

   task automatic t_clear();
      wr_ctrl(8'h00);
      check("R4 write zero keeps flag", {31'd0, crc_err}, 32'd1);
      wr_ctrl(8'h80);
      check("R4 write one clears flag", {31'd0, crc_err}, 32'd0);
      seq_chk(~ref_acc, 1'b1);
      check("R3 mismatch sets flag again", {31'd0, crc_err}, 32'd1);
      reg_sel = 2'd2; reg_rd = 1'b1;
      step();
      reg_rd = 1'b0; #1;
      check("R5 status read clears flag", {31'd0, crc_err}, 32'd0);
      check("R7 irq drops with flag", {31'd0, irq_stat}, 32'd0);
   endtask

   task automatic t_race();
      seq_check = 1'b1; dt_in_active = 1'b1; seq_crc_word = ~ref_acc;
      reg_sel = 2'd0; reg_wr = 1'b1; reg_wdata = 32'h80;
      step();
      seq_check = 1'b0; dt_in_active = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      ref_rx = ~ref_acc;
      check("R6 new error beats clear", {31'd0, crc_err}, 32'd1);
      wr_ctrl(8'h80);
   endtask

   task automatic t_layout();
      wr_ctrl(8'h62);
      reg_sel = 2'd0; #1;
      check("R8 reserved and strobe bits read zero", reg_rdata, 32'h22);
      wr_ctrl(8'h40);
      reg_sel = 2'd0; #1;
      check("R8 bit 6 ignored", reg_rdata, 32'h00);
   endtask

   task automatic t_reseed_paths();
      logic [31:0] v;
      send_word(32'hCAFE_F00D);
      seq_reseed = 1'b1;
      step();
      seq_reseed = 1'b0;
      ref_acc = SEED;
      view(2'd0, v);
      check("R9 sequencer reseed", v, SEED);
      send_word(32'h0BAD_C0DE);
      wr_ctrl(8'h10);
      ref_acc = SEED;
      view(2'd0, v);
      check("R10 test reseed strobe", v, SEED);
   endtask

   task automatic t_auto();
      auto_b = 1;
      wr_ctrl(8'h20);
      send_word(32'h5555_AAAA);
      reg_sel = 2'd1;
      seq_chk(ref_acc, 1'b1);
      reg_sel = 2'd1; #1;
      check("R9 accumulator unchanged right after check", reg_rdata, ref_acc);
      step();
      reg_sel = 2'd1; #1;
      check("R9 auto-seed one cycle later", reg_rdata, SEED);
      ref_acc = SEED;
      auto_b = 0;
      wr_ctrl(8'h00);
   endtask

   task automatic t_test_add_chk();
      logic [31:0] v;
      reg_sel = 2'd1; reg_wr = 1'b1; reg_wdata = 32'h7777_0123;
      step();
      reg_wr = 1'b0;
      view(2'd2, v);
      check("R14 data write loads input register", v, 32'h7777_0123);
      wr_ctrl(8'h04);
      ref_acc = ref_step(ref_acc, 32'h7777_0123);
      view(2'd0, v);
      check("R12 test accumulate", v, ref_acc);
      if (ref_acc == ref_rx) send_word(32'h1);
      wr_ctrl(8'h08);
      check("R11 test check sets flag outside transfer", {31'd0, crc_err}, 32'd1);
      wr_ctrl(8'h80);
      check("R4 clear after test check", {31'd0, crc_err}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_accum();
      t_check_paths();
      t_mismatch_irq();
      t_clear();
      t_race();
      t_layout();
      t_reseed_paths();
      t_auto();
      t_test_add_chk();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule